// File: doc/BRIEF.md
# Conditional-Execution 32-bit Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It fetches a word from a small instruction store, decodes it and executes it in the same cycle. It handles four data-processing operations (add, subtract, bitwise and, bitwise or), word loads and stores with an unsigned immediate offset, and relative branches. Every instruction carries a 4-bit condition in bits 31:28. The instruction takes effect only if that condition holds against the saved negative, zero, carry and overflow flags.

The instruction store is filled through a write port while the core is held in reset. After reset is released, the core runs from byte address 0. The data store's write strobe, byte address and write data are visible at the ports, along with the program counter, the current instruction word and the saved flags. A program shows its results by storing them to memory.

Top module: `cond_exec_cpu`

## Requirements
- R1: While `rst_n` is low, the program counter, all fifteen general registers R0–R14 and the saved flags `flags_o` = {N,Z,C,V} are cleared, so the first fetch after release comes from word 0.
- R2: An instruction that is neither a branch (bits 27:26 = 10) nor an instruction naming R15 as destination moves the program counter to PC+4.
- R3: A data-processing instruction (bits 27:26 = 00) uses command bits 24:21 as follows: 0100 adds, 0010 subtracts, 0000 ands and 1100 ors. It reads Rn from bits 19:16 and writes Rd in bits 15:12. When bit 25 is set, the second operand is the zero-extended byte in bits 7:0; when bit 25 is clear, it is register Rm in bits 3:0.
- R4: The arithmetic flags are set as follows. N is the result's top bit and Z marks a zero result. For a subtraction, C is the carry out of A + ~B + 1, so it is 1 when no borrow occurs. V marks signed overflow. For and/or, the arithmetic unit gives C = V = 0.
- R5: The saved flags change only for an executed data-processing instruction whose S bit (bit 20) is set. Add and subtract update all four flags. And/or update only N and Z and keep the saved C and V.
- R6: Condition codes in bits 31:28 map as follows: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, 1111 never. When the condition fails, the instruction writes no register, no memory and no flags, and it does not redirect the program counter.
- R7: Reading R15 as an operand returns the current PC+8.
- R8: Bits 27:26 = 01 select a memory access. The byte address is Rn plus the zero-extended 12-bit field in bits 11:0, and the word index is address bits 7:2. Bit 20 = 1 loads a word into Rd; bit 20 = 0 stores Rd. The data store is written only by an executed store.
- R9: A branch (bits 27:24 = 1010) that is taken sets the PC to PC+8 plus the sign-extended 24-bit field in bits 23:0 shifted left by 2.
- R10: An executed data-processing instruction or load whose Rd is R15 sends its result to the program counter instead of to a register.
- R11: While `load_en` is high, each clock edge writes `load_data` into instruction word `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Instruction store write enable |
| load_addr | input | 6 | Instruction store word index for loading |
| load_data | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word being executed |
| dmem_we_o | output | 1 | Data store write strobe of the current cycle |
| dmem_addr_o | output | 32 | Data store byte address |
| dmem_wdata_o | output | 32 | Data store write data |
| flags_o | output | 4 | Saved flags {N,Z,C,V} |

## Verification
Some properties are checked on every cycle. The program counter steps by four after any non-branch instruction that does not write R15. A taken branch lands on its computed target. Only store instructions raise the data write strobe, and a failed condition blocks every side effect. Flags stay put unless a data-processing instruction with S set runs. Logical operations give zero carry and overflow from the arithmetic unit, and equal operands under subtraction give Z and C. Other behaviour can only be shown by the bench program's stored results and sampled flags. These include the actual arithmetic values, the PC+8 read of R15, the backward branch loop that builds a value of 2^31, signed overflow in both directions, redirects through R15 by add and by load, and the full set of condition codes.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
   localparam int XLEN      = 32;
   localparam int REG_COUNT = 16;
   localparam int REG_AW    = 4;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_ORR = 2'b11
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_DP8   = 2'b00,
      IMM_MEM12 = 2'b01,
      IMM_BR24  = 2'b10
   } imm_kind_e;

   typedef struct packed {
      logic      reg_we;
      logic      mem_we;
      logic      pc_redirect;
      logic [1:0] flag_we;     // [1]: N/Z, [0]: C/V
      logic      mem_to_reg;
      logic      alu_imm;
      imm_kind_e imm_kind;
      logic [1:0] reg_src;     // [0]: port A reads R15, [1]: port B reads Rd
      alu_op_e   alu_op;
   } ctrl_t;

   // Condition test against saved flags {N,Z,C,V}
   function automatic logic cond_holds(input logic [3:0] code, input logic [3:0] nzcv);
      logic n, z, c, v;
      logic ok;
      n = nzcv[3];
      z = nzcv[2];
      c = nzcv[1];
      v = nzcv[0];
      case (code)
         4'h0:    ok = z;
         4'h1:    ok = !z;
         4'h2:    ok = c;
         4'h3:    ok = !c;
         4'h4:    ok = n;
         4'h5:    ok = !n;
         4'h6:    ok = v;
         4'h7:    ok = !v;
         4'h8:    ok = c && !z;
         4'h9:    ok = !c || z;
         4'hA:    ok = (n == v);
         4'hB:    ok = (n != v);
         4'hC:    ok = !z && (n == v);
         4'hD:    ok = z || (n != v);
         4'hE:    ok = 1'b1;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
   import cpu_pkg::*;
#(
   parameter int W           = XLEN,
   parameter bit SPLIT_ADDER = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic [3:0]   nzcv
);
   localparam int LO = W / 2;
   localparam int HI = W - LO;

   if (W < 8) begin : g_bad_width
      $error("cpu_alu: W must be at least 8");
   end

   logic         is_sub;
   logic         is_arith;
   logic [W-1:0] b_eff;
   logic [W:0]   sum;

   assign is_sub   = (op == ALU_SUB);
   assign is_arith = (op == ALU_ADD) || (op == ALU_SUB);
   assign b_eff    = is_sub ? ~b : b;

   if (SPLIT_ADDER) begin : g_csel
      // Two halves; upper half computed for both carry-ins, picked by lower carry
      logic [LO:0] lo_sum;
      logic [HI:0] hi_c0;
      logic [HI:0] hi_c1;
      assign lo_sum = {1'b0, a[LO-1:0]} + {1'b0, b_eff[LO-1:0]} + {{LO{1'b0}}, is_sub};
      assign hi_c0  = {1'b0, a[W-1:LO]} + {1'b0, b_eff[W-1:LO]};
      assign hi_c1  = hi_c0 + {{HI{1'b0}}, 1'b1};
      assign sum    = lo_sum[LO] ? {hi_c1, lo_sum[LO-1:0]} : {hi_c0, lo_sum[LO-1:0]};
   end else begin : g_ripple
      assign sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
   end

   always_comb begin
      case (op)
         ALU_ADD, ALU_SUB: y = sum[W-1:0];
         ALU_AND:          y = a & b;
         default:          y = a | b;
      endcase
      nzcv[3] = y[W-1];
      nzcv[2] = (y == '0);
      nzcv[1] = is_arith && sum[W];
      nzcv[0] = is_arith && (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
   import cpu_pkg::*;
#(
   parameter int W = XLEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] wa,
   input  logic [W-1:0]      wd,
   input  logic [REG_AW-1:0] ra1,
   input  logic [REG_AW-1:0] ra2,
   input  logic [W-1:0]      pc_plus8,
   output logic [W-1:0]      rd1,
   output logic [W-1:0]      rd2
);
   localparam int STORED = REG_COUNT - 1;
   localparam logic [REG_AW-1:0] PC_IDX = REG_AW'(REG_COUNT - 1);

   if (REG_COUNT != (1 << REG_AW)) begin : g_bad_count
      $error("cpu_regbank: REG_COUNT must equal 2**REG_AW");
   end

   logic [W-1:0] q [STORED];

   for (genvar i = 0; i < STORED; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[i] <= '0;
         end else if (we && (wa == REG_AW'(i))) begin
            q[i] <= wd;
         end
      end
   end

   assign rd1 = (ra1 == PC_IDX) ? pc_plus8 : q[ra1];
   assign rd2 = (ra2 == PC_IDX) ? pc_plus8 : q[ra2];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
   import cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] cond,
   input  logic [1:0] op_cls,
   input  logic [5:0] funct,
   input  logic [3:0] rd,
   input  logic [3:0] alu_nzcv,
   output logic       reg_we,
   output logic       mem_we,
   output logic       pc_src,
   output logic       mem_to_reg,
   output logic       alu_imm,
   output imm_kind_e  imm_kind,
   output logic [1:0] reg_src,
   output alu_op_e    alu_op,
   output logic [3:0] nzcv_q
);
   ctrl_t      dec;
   logic       known;
   logic       is_branch;
   logic       cond_ok;
   logic [1:0] flag_we_g;
   logic [3:0] cmd;
   logic       s_bit;

   assign cmd   = funct[4:1];
   assign s_bit = funct[0];

   always_comb begin
      dec          = '0;
      dec.alu_op   = ALU_ADD;
      dec.imm_kind = IMM_DP8;
      known        = 1'b0;
      is_branch    = 1'b0;
      case (op_cls)
         2'b00: begin
            dec.alu_imm = funct[5];
            known       = 1'b1;
            case (cmd)
               4'b0100: dec.alu_op = ALU_ADD;
               4'b0010: dec.alu_op = ALU_SUB;
               4'b0000: dec.alu_op = ALU_AND;
               4'b1100: dec.alu_op = ALU_ORR;
               default: known = 1'b0;
            endcase
            dec.reg_we     = known;
            dec.flag_we[1] = known && s_bit;
            dec.flag_we[0] = known && s_bit &&
                             ((dec.alu_op == ALU_ADD) || (dec.alu_op == ALU_SUB));
         end
         2'b01: begin
            dec.alu_imm  = 1'b1;
            dec.imm_kind = IMM_MEM12;
            if (s_bit) begin
               dec.reg_we     = 1'b1;
               dec.mem_to_reg = 1'b1;
            end else begin
               dec.mem_we     = 1'b1;
               dec.reg_src[1] = 1'b1;
            end
         end
         2'b10: begin
            dec.alu_imm    = 1'b1;
            dec.imm_kind   = IMM_BR24;
            dec.reg_src[0] = 1'b1;
            is_branch      = 1'b1;
         end
         default: ;
      endcase
      dec.pc_redirect = is_branch || (dec.reg_we && (rd == 4'hF));
   end

   assign cond_ok    = cond_holds(cond, nzcv_q);
   assign reg_we     = dec.reg_we && cond_ok;
   assign mem_we     = dec.mem_we && cond_ok;
   assign pc_src     = dec.pc_redirect && cond_ok;
   assign flag_we_g  = cond_ok ? dec.flag_we : 2'b00;
   assign mem_to_reg = dec.mem_to_reg;
   assign alu_imm    = dec.alu_imm;
   assign imm_kind   = dec.imm_kind;
   assign reg_src    = dec.reg_src;
   assign alu_op     = dec.alu_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nzcv_q <= 4'b0000;
      end else begin
         if (flag_we_g[1]) nzcv_q[3:2] <= alu_nzcv[3:2];
         if (flag_we_g[0]) nzcv_q[1:0] <= alu_nzcv[1:0];
      end
   end

   // R5: only a data-processing instruction with S set may touch the flags
   p_flags_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !((op_cls == 2'b00) && s_bit) |=> $stable(nzcv_q));

   // R6: a failing condition blocks every side effect
   p_cond_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cond_holds(cond, nzcv_q) |-> !(reg_we || mem_we || pc_src));
endmodule

// File: rtl/cpu_word_mem.sv
module cpu_word_mem #(
   parameter int WORDS = 64,
   parameter int W     = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [W-1:0]             rdata
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_depth
      $error("cpu_word_mem: WORDS must be a power of two of at least 2");
   end

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cond_exec_cpu.sv
module cond_exec_cpu
   import cpu_pkg::*;
#(
   parameter int IMEM_WORDS  = 64,
   parameter int DMEM_WORDS  = 64,
   parameter bit SPLIT_ADDER = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_en,
   input  logic [$clog2(IMEM_WORDS)-1:0] load_addr,
   input  logic [31:0]                   load_data,
   output logic [31:0]                   pc_o,
   output logic [31:0]                   instr_o,
   output logic                          dmem_we_o,
   output logic [31:0]                   dmem_addr_o,
   output logic [31:0]                   dmem_wdata_o,
   output logic [3:0]                    flags_o
);
   localparam int IMEM_AW = $clog2(IMEM_WORDS);
   localparam int DMEM_AW = $clog2(DMEM_WORDS);

   if (XLEN != 32) begin : g_bad_xlen
      $error("cond_exec_cpu: instruction encoding needs a 32-bit datapath");
   end
   if (IMEM_AW + 2 > XLEN || DMEM_AW + 2 > XLEN) begin : g_bad_mem
      $error("cond_exec_cpu: memory too deep for the address width");
   end

   logic [XLEN-1:0]   pc;
   logic [XLEN-1:0]   pc_plus4;
   logic [XLEN-1:0]   pc_plus8;
   logic [XLEN-1:0]   instr;
   logic [XLEN-1:0]   src_a;
   logic [XLEN-1:0]   rd2;
   logic [XLEN-1:0]   src_b;
   logic [XLEN-1:0]   ext_imm;
   logic [XLEN-1:0]   alu_y;
   logic [3:0]        alu_nzcv;
   logic [XLEN-1:0]   load_word;
   logic [XLEN-1:0]   result;
   logic [REG_AW-1:0] ra1;
   logic [REG_AW-1:0] ra2;
   logic              reg_we;
   logic              mem_we;
   logic              pc_src;
   logic              mem_to_reg;
   logic              alu_imm;
   imm_kind_e         imm_kind;
   logic [1:0]        reg_src;
   alu_op_e           alu_op;
   logic [3:0]        nzcv_q;

   // Fetch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_src ? result : pc_plus4;
   end

   assign pc_plus4 = pc + XLEN'(4);
   assign pc_plus8 = pc_plus4 + XLEN'(4);

   cpu_word_mem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
      .clk   (clk),
      .we    (load_en),
      .waddr (load_addr),
      .wdata (load_data),
      .raddr (pc[IMEM_AW+1:2]),
      .rdata (instr)
   );

   // Decode and condition
   cpu_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cond       (instr[31:28]),
      .op_cls     (instr[27:26]),
      .funct      (instr[25:20]),
      .rd         (instr[15:12]),
      .alu_nzcv   (alu_nzcv),
      .reg_we     (reg_we),
      .mem_we     (mem_we),
      .pc_src     (pc_src),
      .mem_to_reg (mem_to_reg),
      .alu_imm    (alu_imm),
      .imm_kind   (imm_kind),
      .reg_src    (reg_src),
      .alu_op     (alu_op),
      .nzcv_q     (nzcv_q)
   );

   // Operands
   assign ra1 = reg_src[0] ? REG_AW'(REG_COUNT - 1) : instr[19:16];
   assign ra2 = reg_src[1] ? instr[15:12] : instr[3:0];

   cpu_regbank #(.W(XLEN)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .wa       (instr[15:12]),
      .wd       (result),
      .ra1      (ra1),
      .ra2      (ra2),
      .pc_plus8 (pc_plus8),
      .rd1      (src_a),
      .rd2      (rd2)
   );

   always_comb begin
      case (imm_kind)
         IMM_DP8:   ext_imm = {{(XLEN-8){1'b0}}, instr[7:0]};
         IMM_MEM12: ext_imm = {{(XLEN-12){1'b0}}, instr[11:0]};
         default:   ext_imm = {{(XLEN-26){instr[23]}}, instr[23:0], 2'b00};
      endcase
   end

   assign src_b = alu_imm ? ext_imm : rd2;

   // Execute
   cpu_alu #(.W(XLEN), .SPLIT_ADDER(SPLIT_ADDER)) u_alu (
      .a    (src_a),
      .b    (src_b),
      .op   (alu_op),
      .y    (alu_y),
      .nzcv (alu_nzcv)
   );

   // Memory and write-back
   cpu_word_mem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (alu_y[DMEM_AW+1:2]),
      .wdata (rd2),
      .raddr (alu_y[DMEM_AW+1:2]),
      .rdata (load_word)
   );

   assign result = mem_to_reg ? load_word : alu_y;

   assign pc_o         = pc;
   assign instr_o      = instr;
   assign dmem_we_o    = mem_we;
   assign dmem_addr_o  = alu_y;
   assign dmem_wdata_o = rd2;
   assign flags_o      = nzcv_q;

   // R2: no branch and no R15 destination means a plain step
   p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((instr[27:26] != 2'b10) && (instr[15:12] != 4'hF)) |=> (pc == $past(pc) + 32'd4));

   // R9: a taken branch lands on PC+8 plus the scaled offset
   p_branch_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src && (instr[27:26] == 2'b10)) |=>
      (pc == $past(pc) + 32'd8 + {{6{$past(instr[23])}}, $past(instr[23:0]), 2'b00}));

   // R8: the write strobe comes only from store instructions
   p_store_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we_o |-> ((instr[27:26] == 2'b01) && !instr[20]));

   // R4: logical operations leave carry and overflow clear
   p_logic_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((alu_op == ALU_AND) || (alu_op == ALU_ORR)) |-> (alu_nzcv[1:0] == 2'b00));

   // R4: subtracting equal operands gives zero with no borrow
   p_sub_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((alu_op == ALU_SUB) && (src_a == src_b)) |-> (alu_nzcv[2] && alu_nzcv[1]));
endmodule

// File: tb/cond_exec_cpu_tb.sv
`timescale 1ns/1ps
module cond_exec_cpu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic [5:0]  load_addr = '0;
   logic [31:0] load_data = '0;
   logic [31:0] pc_o;
   logic [31:0] instr_o;
   logic        dmem_we_o;
   logic [31:0] dmem_addr_o;
   logic [31:0] dmem_wdata_o;
   logic [3:0]  flags_o;

   always #2 clk = ~clk;

   cond_exec_cpu u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (load_en),
      .load_addr    (load_addr),
      .load_data    (load_data),
      .pc_o         (pc_o),
      .instr_o      (instr_o),
      .dmem_we_o    (dmem_we_o),
      .dmem_addr_o  (dmem_addr_o),
      .dmem_wdata_o (dmem_wdata_o),
      .flags_o      (flags_o)
   );

   typedef struct {
      string       tag;
      logic [31:0] addr;
      logic [31:0] data;
   } store_item_t;

   store_item_t exp_q[$];
   logic [31:0] prog [64];
   int          total = 0;
   int          bad = 0;
   logic        running = 1'b0;

   localparam logic [3:0] EQ = 4'h0, NE = 4'h1, CS = 4'h2, CC = 4'h3, MI = 4'h4, PL = 4'h5,
                          VS = 4'h6, VC = 4'h7, HI = 4'h8, LS = 4'h9, GE = 4'hA, LT = 4'hB,
                          GT = 4'hC, LE = 4'hD, AL = 4'hE, NV = 4'hF;
   localparam logic [3:0] C_ADD = 4'b0100, C_SUB = 4'b0010, C_AND = 4'b0000, C_ORR = 4'b1100;

   function automatic logic [31:0] dp(logic [3:0] c, logic i, logic [3:0] cmd, logic s,
                                      logic [3:0] rn, logic [3:0] rd, logic [11:0] src);
      return {c, 2'b00, i, cmd, s, rn, rd, src};
   endfunction

   function automatic logic [31:0] mem(logic [3:0] c, logic l, logic [3:0] rn,
                                       logic [3:0] rd, logic [11:0] off);
      return {c, 2'b01, 1'b0, 4'b1100, l, rn, rd, off};
   endfunction

   function automatic logic [31:0] br(logic [3:0] c, logic [23:0] off);
      return {c, 4'b1010, off};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_store(string tag, logic [31:0] a, logic [31:0] d);
      store_item_t it;
      it.tag  = tag;
      it.addr = a;
      it.data = d;
      exp_q.push_back(it);
   endtask

   // Monitor: compares stores against the scoreboard and samples flags at chosen PCs
   always @(negedge clk) begin
      if (running) begin
         if (dmem_we_o) begin
            if (exp_q.size() == 0) begin
               total++;
               bad++;
               $display("FAIL R6/R8 unexpected store actual=%h:%h expected=none",
                        dmem_addr_o, dmem_wdata_o);
            end else begin
               store_item_t it;
               it = exp_q.pop_front();
               check({it.tag, " store addr"}, dmem_addr_o, it.addr);
               check({it.tag, " store data"}, dmem_wdata_o, it.data);
            end
         end
         case (pc_o)
            32'd12:  check("R4 SUB borrow flags", {28'd0, flags_o}, 32'h8);
            32'd20:  check("R4 SUB no-borrow flags", {28'd0, flags_o}, 32'h2);
            32'd28:  check("R5 AND keeps C/V", {28'd0, flags_o}, 32'h2);
            32'd48:  check("R4 zero result flags", {28'd0, flags_o}, 32'h6);
            32'd52:  check("R5 no S keeps flags", {28'd0, flags_o}, 32'h6);
            32'd92:  check("R4 SUB overflow flags", {28'd0, flags_o}, 32'h3);
            32'd100: check("R4 ADD overflow flags", {28'd0, flags_o}, 32'h9);
            default: ;
         endcase
      end
   end

   initial begin
      int stable_cnt;
      bit done;
      for (int i = 0; i < 64; i++) prog[i] = {NV, 28'd0};
      prog[0]  = dp(AL, 1, C_ADD, 0, 4'd0, 4'd1, 12'd5);
      prog[1]  = dp(AL, 1, C_ADD, 0, 4'd0, 4'd2, 12'd3);
      prog[2]  = dp(AL, 0, C_SUB, 1, 4'd2, 4'd4, 12'd1);     // 3-5
      prog[3]  = mem(AL, 0, 4'd0, 4'd4, 12'd4);
      prog[4]  = dp(AL, 0, C_SUB, 1, 4'd1, 4'd3, 12'd2);     // 5-3
      prog[5]  = mem(AL, 0, 4'd0, 4'd3, 12'd0);
      prog[6]  = dp(AL, 0, C_AND, 1, 4'd1, 4'd5, 12'd2);
      prog[7]  = dp(AL, 0, C_ORR, 0, 4'd1, 4'd6, 12'd2);
      prog[8]  = mem(AL, 0, 4'd0, 4'd6, 12'd8);
      prog[9]  = dp(AL, 1, C_ADD, 0, 4'd15, 4'd7, 12'd0);
      prog[10] = mem(AL, 0, 4'd0, 4'd7, 12'd12);
      prog[11] = dp(AL, 0, C_SUB, 1, 4'd1, 4'd8, 12'd1);
      prog[12] = dp(NE, 1, C_ADD, 0, 4'd0, 4'd9, 12'd1);
      prog[13] = dp(EQ, 1, C_ADD, 0, 4'd0, 4'd10, 12'd9);
      prog[14] = mem(NE, 0, 4'd0, 4'd1, 12'd16);
      prog[15] = mem(AL, 0, 4'd0, 4'd9, 12'd20);
      prog[16] = mem(AL, 0, 4'd0, 4'd10, 12'd24);
      prog[17] = dp(AL, 1, C_ADD, 0, 4'd0, 4'd12, 12'd1);
      prog[18] = dp(AL, 1, C_ADD, 0, 4'd0, 4'd13, 12'd31);
      prog[19] = dp(AL, 0, C_ADD, 0, 4'd12, 4'd12, 12'd12);
      prog[20] = dp(AL, 1, C_SUB, 1, 4'd13, 4'd13, 12'd1);
      prog[21] = br(NE, 24'hFFFFFC);
      prog[22] = dp(AL, 1, C_SUB, 1, 4'd12, 4'd14, 12'd1);
      prog[23] = mem(VS, 0, 4'd0, 4'd14, 12'd28);
      prog[24] = dp(AL, 1, C_ADD, 1, 4'd14, 4'd11, 12'd1);
      prog[25] = mem(MI, 0, 4'd0, 4'd11, 12'd32);
      prog[26] = mem(AL, 1, 4'd0, 4'd9, 12'd4);
      prog[27] = dp(AL, 1, C_ADD, 0, 4'd9, 4'd9, 12'd3);
      prog[28] = mem(AL, 0, 4'd0, 4'd9, 12'd36);
      prog[29] = br(LT, 24'h000010);
      prog[30] = br(GE, 24'h000000);
      prog[31] = mem(AL, 0, 4'd0, 4'd1, 12'd40);
      prog[32] = dp(AL, 1, C_ADD, 0, 4'd0, 4'd15, 12'd136);
      prog[33] = mem(AL, 0, 4'd0, 4'd1, 12'd44);
      prog[34] = dp(AL, 1, C_ADD, 0, 4'd0, 4'd6, 12'd152);
      prog[35] = mem(AL, 0, 4'd0, 4'd6, 12'd48);
      prog[36] = mem(AL, 1, 4'd0, 4'd15, 12'd48);
      prog[37] = mem(AL, 0, 4'd0, 4'd1, 12'd52);
      prog[38] = mem(HI, 0, 4'd0, 4'd1, 12'd56);
      prog[39] = mem(LS, 0, 4'd0, 4'd2, 12'd60);
      prog[40] = mem(GT, 0, 4'd0, 4'd3, 12'd64);
      prog[41] = mem(LE, 0, 4'd0, 4'd1, 12'd68);
      prog[42] = mem(CC, 0, 4'd0, 4'd5, 12'd72);
      prog[43] = mem(PL, 0, 4'd0, 4'd1, 12'd76);
      prog[44] = mem(VC, 0, 4'd0, 4'd1, 12'd80);
      prog[45] = mem(CS, 0, 4'd0, 4'd1, 12'd84);
      prog[46] = mem(NV, 0, 4'd0, 4'd1, 12'd88);
      prog[47] = br(AL, 24'hFFFFFE);

      // Driver: expected stores in program order
      expect_store("R3 R4 SUB 3-5",       32'd4,  32'hFFFF_FFFE);
      expect_store("R3 SUB 5-3",          32'd0,  32'd2);
      expect_store("R3 ORR register",     32'd8,  32'd7);
      expect_store("R7 R15 reads PC+8",   32'd12, 32'd44);
      expect_store("R6 NE suppressed",    32'd20, 32'd0);
      expect_store("R6 EQ executed",      32'd24, 32'd9);
      expect_store("R9 loop, R6 VS",      32'd28, 32'h7FFF_FFFF);
      expect_store("R6 MI executed",      32'd32, 32'h8000_0000);
      expect_store("R8 load then add",    32'd36, 32'd1);
      expect_store("R10 via ADD to R15",  32'd48, 32'd152);
      expect_store("R10 LDR R15, R6 LS",  32'd60, 32'd3);
      expect_store("R6 GT executed",      32'd64, 32'd2);
      expect_store("R6 CC executed",      32'd72, 32'd1);

      // Preload instruction store while held in reset
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_addr = 6'(i);
         load_data = prog[i];
      end
      @(negedge clk);
      load_en = 1'b0;
      @(negedge clk);
      check("R1 reset PC", pc_o, 32'd0);
      check("R1 reset flags", {28'd0, flags_o}, 32'd0);
      check("R11 preloaded word 0", instr_o, prog[0]);

      rst_n   = 1'b1;
      running = 1'b1;
      @(negedge clk);
      check("R2 first step", pc_o, 32'd4);

      // Run with watchdog until the final self-branch is reached
      stable_cnt = 0;
      done = 1'b0;
      for (int n = 0; n < 3000 && !done; n++) begin
         @(negedge clk);
         if (pc_o == 32'd188) stable_cnt++;
         else                 stable_cnt = 0;
         if (stable_cnt >= 4) done = 1'b1;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog actual=%h expected=%h", pc_o, 32'd188);
      end
      check("R9 self branch holds PC", pc_o, 32'd188);
      check("R8 all expected stores seen", 32'(exp_q.size()), 32'd0);
      running = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule